// File: doc/BRIEF.md
# Branch and Skip Resolution Unit

This unit sits next to the decoder of a small 8-bit processor core. It takes one resolved control-flow request per clock. Each request carries the address of the current instruction, an operation code, the status byte, a packed offset field, two register operands and a flag that tells whether the instruction that follows is two words long. From these it produces the address of the next instruction, a taken indication and the number of cycles the operation spends. The fetch stage uses the address and the sequencer uses the cycle count.

The unit handles five kinds of operation. A plain step advances by one. A relative jump always leaves the straight path. A conditional branch tests any one status bit for set or for clear. Three skip forms test operand equality, or test one operand bit for set or clear. A skip that fires jumps over the next instruction, so how far it advances, and how many cycles it costs, depends on that instruction's length. All address arithmetic wraps modulo the program-counter width. The result is registered and appears exactly one clock after the request.

Top module: `bsr_unit`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and until the first request, res_valid, res_taken, res_cycles and res_pc are all zero.
- R2: Operation code 0 (step), and the reserved code 7, give res_pc = req_pc + 1, res_taken = 0 and res_cycles = 1.
- R3: Operation code 1 (relative jump) gives res_pc = req_pc + sign-extended req_offset[11:0] + 1, res_taken = 1 and res_cycles = 2, wrapping modulo 2^PC_W.
- R4: Operation code 2 (branch if set) tests req_sreg[req_sel], where bit 0 is carry, 1 zero, 2 negative, 3 overflow, 4 sign, 5 half carry, 6 transfer and 7 interrupt enable. When the bit is 1 it gives res_pc = req_pc + sign-extended req_offset[6:0] + 1, taken 1 and 2 cycles. Otherwise it gives req_pc + 1, taken 0 and 1 cycle.
- R5: Operation code 3 (branch if clear) behaves like R4 but is taken when the selected status bit is 0. Signed greater-or-equal is code 3 on bit 4, and unsigned same-or-higher is code 3 on bit 0.
- R6: For branches only req_offset[6:0] is used. Bits 11:7 have no effect, and an offset of 7'h40 steps back by 64.
- R7: Operation code 4 (skip if equal) fires when req_opa == req_opb. A fired skip gives taken 1 with res_pc = req_pc + 2 and 2 cycles when req_next_long = 0, or req_pc + 3 and 3 cycles when req_next_long = 1. A skip that does not fire gives req_pc + 1, taken 0 and 1 cycle.
- R8: Operation codes 5 and 6 (skip if bit set or clear) fire when req_opa[req_sel] is 1 or 0 respectively, with the same results as R7.
- R9: Each request raises res_valid in exactly the one cycle after it is sampled, back-to-back requests give back-to-back results, and res_valid is 0 after a cycle with no request.
- R10: req_next_long has no effect on step, jump and branch results.
- R11: Every result has res_cycles between 1 and 3, and any taken result has res_cycles of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2 to R8) |
| req_pc | input | PC_W (16) | Address of the current instruction |
| req_sreg | input | SREG_W (8) | Status byte |
| req_sel | input | SEL_W (3) | Status bit index for branches, operand bit index for bit skips |
| req_offset | input | JMP_OFF_W (12) | Signed offset; branches use the low BR_OFF_W (7) bits |
| req_opa | input | DATA_W (8) | First register operand |
| req_opb | input | DATA_W (8) | Second register operand |
| req_next_long | input | 1 | Following instruction occupies two words |
| res_valid | output | 1 | Result present |
| res_pc | output | PC_W (16) | Next instruction address |
| res_taken | output | 1 | Control flow left the straight path |
| res_cycles | output | 2 | Cycle count of the operation |

## Verification
Branches are tried against a status byte with mixed ones and zeros for every bit index, with both polarities. This separates a wrong bit index from an inverted test. Offsets are chosen with junk in the upper field bits, at the most negative 7-bit and 12-bit values, and near address zero and the top of the address space. These catch a wrong sign-extension width, a missing +1 and a failure to wrap. Skips are run with equal and unequal operands, with bit patterns where set and clear differ, and with both next-instruction lengths, so a wrong +2/+3 choice or a wrong cycle count shows up. Requests go back-to-back and with gaps, which exposes latency or valid-tracking errors.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [2:0] {
      OP_STEP      = 3'd0,
      OP_RJMP      = 3'd1,
      OP_BR_SET    = 3'd2,
      OP_BR_CLR    = 3'd3,
      OP_SKIP_EQ   = 3'd4,
      OP_SKIP_BSET = 3'd5,
      OP_SKIP_BCLR = 3'd6,
      OP_RSVD      = 3'd7
   } bsr_op_e;

   localparam int OP_W  = 3;
   localparam int CYC_W = 2;

   // status byte bit positions
   localparam int FLG_CARRY = 0;
   localparam int FLG_ZERO  = 1;
   localparam int FLG_NEG   = 2;
   localparam int FLG_OVF   = 3;
   localparam int FLG_SIGN  = 4;
   localparam int FLG_HALF  = 5;
   localparam int FLG_XFER  = 6;
   localparam int FLG_IEN   = 7;

endpackage

// File: rtl/bsr_cond.sv
// Evaluates the branch or skip condition for one request.
module bsr_cond
   import bsr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SREG_W = 8,
   parameter int SEL_W  = 3
) (
   input  bsr_op_e             op,
   input  logic [SREG_W-1:0]   sreg,
   input  logic [SEL_W-1:0]    sel,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   output logic                cond_hit
);

   logic [DATA_W-1:0] diff_bits;
   logic              ops_equal;
   logic              flag_bit;
   logic              data_bit;

   // per-bit equality, reduced below
   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_eq
         assign diff_bits[gi] = opa[gi] ^ opb[gi];
      end
   endgenerate

   assign ops_equal = ~|diff_bits;
   assign flag_bit  = sreg[sel];
   assign data_bit  = opa[sel];

   always_comb begin
      unique case (op)
         OP_BR_SET:    cond_hit = flag_bit;
         OP_BR_CLR:    cond_hit = ~flag_bit;
         OP_SKIP_EQ:   cond_hit = ops_equal;
         OP_SKIP_BSET: cond_hit = data_bit;
         OP_SKIP_BCLR: cond_hit = ~data_bit;
         OP_RJMP:      cond_hit = 1'b1;
         default:      cond_hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/bsr_target.sv
// Computes every candidate next address in parallel.
module bsr_target #(
   parameter int PC_W      = 16,
   parameter int BR_OFF_W  = 7,
   parameter int JMP_OFF_W = 12
) (
   input  logic [PC_W-1:0]      pc,
   input  logic [JMP_OFF_W-1:0] offset,
   input  logic                 next_long,
   output logic [PC_W-1:0]      step_pc,
   output logic [PC_W-1:0]      br_pc,
   output logic [PC_W-1:0]      jmp_pc,
   output logic [PC_W-1:0]      skip_pc
);

   localparam int BR_EXT  = PC_W - BR_OFF_W;
   localparam int JMP_EXT = PC_W - JMP_OFF_W;

   logic [PC_W-1:0] br_off_x;
   logic [PC_W-1:0] jmp_off_x;
   logic [PC_W-1:0] skip_dist;

   assign br_off_x  = {{BR_EXT{offset[BR_OFF_W-1]}}, offset[BR_OFF_W-1:0]};
   assign jmp_off_x = {{JMP_EXT{offset[JMP_OFF_W-1]}}, offset};

   assign step_pc   = pc + PC_W'(1);
   assign br_pc     = step_pc + br_off_x;
   assign jmp_pc    = step_pc + jmp_off_x;
   assign skip_dist = next_long ? PC_W'(3) : PC_W'(2);
   assign skip_pc   = pc + skip_dist;

endmodule

// File: rtl/bsr_select.sv
// Picks the next address, taken flag and cycle count.
module bsr_select
   import bsr_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  bsr_op_e           op,
   input  logic              cond_hit,
   input  logic              next_long,
   input  logic [PC_W-1:0]   step_pc,
   input  logic [PC_W-1:0]   br_pc,
   input  logic [PC_W-1:0]   jmp_pc,
   input  logic [PC_W-1:0]   skip_pc,
   output logic [PC_W-1:0]   nxt_pc,
   output logic              taken,
   output logic [CYC_W-1:0]  cycles
);

   always_comb begin
      nxt_pc = step_pc;
      taken  = 1'b0;
      cycles = CYC_W'(1);
      unique case (op)
         OP_RJMP: begin
            nxt_pc = jmp_pc;
            taken  = 1'b1;
            cycles = CYC_W'(2);
         end
         OP_BR_SET, OP_BR_CLR: begin
            if (cond_hit) begin
               nxt_pc = br_pc;
               taken  = 1'b1;
               cycles = CYC_W'(2);
            end
         end
         OP_SKIP_EQ, OP_SKIP_BSET, OP_SKIP_BCLR: begin
            if (cond_hit) begin
               nxt_pc = skip_pc;
               taken  = 1'b1;
               cycles = next_long ? CYC_W'(3) : CYC_W'(2);
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bsr_unit.sv
module bsr_unit
   import bsr_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int DATA_W    = 8,
   parameter int SREG_W    = 8,
   parameter int BR_OFF_W  = 7,
   parameter int JMP_OFF_W = 12,
   parameter bit REG_OUT   = 1'b1,
   localparam int SEL_W    = $clog2(DATA_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [OP_W-1:0]       req_op,
   input  logic [PC_W-1:0]       req_pc,
   input  logic [SREG_W-1:0]     req_sreg,
   input  logic [SEL_W-1:0]      req_sel,
   input  logic [JMP_OFF_W-1:0]  req_offset,
   input  logic [DATA_W-1:0]     req_opa,
   input  logic [DATA_W-1:0]     req_opb,
   input  logic                  req_next_long,
   output logic                  res_valid,
   output logic [PC_W-1:0]       res_pc,
   output logic                  res_taken,
   output logic [CYC_W-1:0]      res_cycles
);

   // elaboration-time parameter checks
   if (PC_W <= JMP_OFF_W) begin : g_bad_pc_w
      $error("PC_W must exceed JMP_OFF_W");
   end
   if (JMP_OFF_W < BR_OFF_W) begin : g_bad_off_w
      $error("JMP_OFF_W must be at least BR_OFF_W");
   end
   if (BR_OFF_W < 2) begin : g_bad_br_w
      $error("BR_OFF_W must be at least 2");
   end
   if (DATA_W != (1 << SEL_W)) begin : g_bad_data_w
      $error("DATA_W must be a power of two");
   end
   if (SREG_W != DATA_W) begin : g_bad_sreg_w
      $error("SREG_W must equal DATA_W");
   end

   bsr_op_e          op_e;
   logic             cond_hit;
   logic [PC_W-1:0]  step_pc, br_pc, jmp_pc, skip_pc;
   logic [PC_W-1:0]  nxt_pc;
   logic             nxt_taken;
   logic [CYC_W-1:0] nxt_cycles;

   assign op_e = bsr_op_e'(req_op);

   bsr_cond #(
      .DATA_W (DATA_W),
      .SREG_W (SREG_W),
      .SEL_W  (SEL_W)
   ) u_cond (
      .op       (op_e),
      .sreg     (req_sreg),
      .sel      (req_sel),
      .opa      (req_opa),
      .opb      (req_opb),
      .cond_hit (cond_hit)
   );

   bsr_target #(
      .PC_W      (PC_W),
      .BR_OFF_W  (BR_OFF_W),
      .JMP_OFF_W (JMP_OFF_W)
   ) u_target (
      .pc        (req_pc),
      .offset    (req_offset),
      .next_long (req_next_long),
      .step_pc   (step_pc),
      .br_pc     (br_pc),
      .jmp_pc    (jmp_pc),
      .skip_pc   (skip_pc)
   );

   bsr_select #(
      .PC_W (PC_W)
   ) u_select (
      .op        (op_e),
      .cond_hit  (cond_hit),
      .next_long (req_next_long),
      .step_pc   (step_pc),
      .br_pc     (br_pc),
      .jmp_pc    (jmp_pc),
      .skip_pc   (skip_pc),
      .nxt_pc    (nxt_pc),
      .taken     (nxt_taken),
      .cycles    (nxt_cycles)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_valid  <= 1'b0;
               res_pc     <= '0;
               res_taken  <= 1'b0;
               res_cycles <= '0;
            end else begin
               res_valid <= req_valid;
               if (req_valid) begin
                  res_pc     <= nxt_pc;
                  res_taken  <= nxt_taken;
                  res_cycles <= nxt_cycles;
               end
            end
         end

         // R9: one result exactly one cycle after each request
         p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> res_valid);
         p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !res_valid);

         // R11: cycle count bounds
         p_cycles_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> (res_cycles >= CYC_W'(1) && res_cycles <= CYC_W'(3)));
         p_taken_cycles_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && res_taken) |-> res_cycles >= CYC_W'(2));

         // R2: plain step moves by one and is never taken
         p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && $past(req_op) == OP_W'(OP_STEP)) |->
            (!res_taken && res_pc == $past(req_pc) + PC_W'(1)));

         // R3: jump is always taken with two cycles
         p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && $past(req_op) == OP_W'(OP_RJMP)) |->
            (res_taken && res_cycles == CYC_W'(2)));

         // R7: a fired skip advances by two or three, matching its cycles
         p_skip_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && res_taken && $past(req_op) >= OP_W'(OP_SKIP_EQ)
             && $past(req_op) <= OP_W'(OP_SKIP_BCLR)) |->
            (res_pc == $past(req_pc) + PC_W'(res_cycles)));
      end else begin : g_comb
         assign res_valid  = req_valid;
         assign res_pc     = nxt_pc;
         assign res_taken  = nxt_taken;
         assign res_cycles = nxt_cycles;
      end
   endgenerate

endmodule

// File: tb/bsr_unit_bench.sv
`timescale 1ns/1ps
module bsr_unit_bench;
   import bsr_pkg::*;

   localparam int PC_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [15:0] req_pc = '0;
   logic [7:0]  req_sreg = '0;
   logic [2:0]  req_sel = '0;
   logic [11:0] req_offset = '0;
   logic [7:0]  req_opa = '0;
   logic [7:0]  req_opb = '0;
   logic        req_next_long = 1'b0;
   logic        res_valid;
   logic [15:0] res_pc;
   logic        res_taken;
   logic [1:0]  res_cycles;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   int unsigned cyc_cnt  = 0;
   bit          done     = 1'b0;

   typedef struct {
      logic [15:0] pc;
      logic        taken;
      logic [1:0]  cyc;
      int unsigned issue;
      string       tag;
   } exp_t;

   exp_t exp_q[$];

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   bsr_unit u_bsr_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_op        (req_op),
      .req_pc        (req_pc),
      .req_sreg      (req_sreg),
      .req_sel       (req_sel),
      .req_offset    (req_offset),
      .req_opa       (req_opa),
      .req_opb       (req_opb),
      .req_next_long (req_next_long),
      .res_valid     (res_valid),
      .res_pc        (res_pc),
      .res_taken     (res_taken),
      .res_cycles    (res_cycles)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // reference model written from the requirements
   function automatic exp_t model(input logic [2:0] op, input logic [15:0] pc,
                                  input logic [7:0] sreg, input logic [2:0] sel,
                                  input logic [11:0] off, input logic [7:0] a,
                                  input logic [7:0] b, input logic lng);
      exp_t e;
      logic hit;
      logic [15:0] o7, o12;
      o7  = {{9{off[6]}}, off[6:0]};
      o12 = {{4{off[11]}}, off};
      e.pc = pc + 16'd1; e.taken = 1'b0; e.cyc = 2'd1;
      e.issue = 0; e.tag = "";
      case (op)
         3'd1: begin e.pc = pc + o12 + 16'd1; e.taken = 1'b1; e.cyc = 2'd2; end
         3'd2, 3'd3: begin
            hit = (op == 3'd2) ? sreg[sel] : !sreg[sel];
            if (hit) begin e.pc = pc + o7 + 16'd1; e.taken = 1'b1; e.cyc = 2'd2; end
         end
         3'd4, 3'd5, 3'd6: begin
            if (op == 3'd4)      hit = (a == b);
            else if (op == 3'd5) hit = a[sel];
            else                 hit = !a[sel];
            if (hit) begin
               e.pc = pc + (lng ? 16'd3 : 16'd2);
               e.taken = 1'b1;
               e.cyc = lng ? 2'd3 : 2'd2;
            end
         end
         default: ;
      endcase
      return e;
   endfunction

   task automatic send(input string tag, input logic [2:0] op, input logic [15:0] pc,
                       input logic [7:0] sreg, input logic [2:0] sel,
                       input logic [11:0] off, input logic [7:0] a,
                       input logic [7:0] b, input logic lng);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_pc = pc; req_sreg = sreg;
      req_sel = sel; req_offset = off; req_opa = a; req_opb = b;
      req_next_long = lng;
      e = model(op, pc, sreg, sel, off, a, b, lng);
      e.issue = cyc_cnt;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && !done && res_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected res_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(cyc_cnt == e.issue + 1, "R9", "latency", cyc_cnt - e.issue, 32'd1);
            check(res_pc == e.pc, e.tag, "res_pc", 32'(res_pc), 32'(e.pc));
            check(res_taken == e.taken, e.tag, "res_taken", 32'(res_taken), 32'(e.taken));
            check(res_cycles == e.cyc, e.tag, "res_cycles", 32'(res_cycles), 32'(e.cyc));
            check(res_cycles >= 2'd1 && (!res_taken || res_cycles >= 2'd2), "R11",
                  "cycle bounds", 32'(res_cycles), 32'd2);
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_errors++;
         $display("FAIL R9 watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0 && res_taken == 1'b0 && res_cycles == 2'd0 && res_pc == 16'd0,
            "R1", "outputs in reset", {res_valid, res_taken, res_cycles, res_pc}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0 && res_pc == 16'd0, "R1", "outputs after release",
            {res_valid, res_pc}, 32'd0);

      // R2 / R10: step and reserved code, next-long flag irrelevant
      send("R2",  3'd0, 16'h1234, 8'hFF, 3'd1, 12'h7FF, 8'h00, 8'h00, 1'b0);
      send("R10", 3'd0, 16'hFFFF, 8'h00, 3'd0, 12'h000, 8'h00, 8'h00, 1'b1);
      send("R2",  3'd7, 16'h0100, 8'hFF, 3'd7, 12'h005, 8'h11, 8'h11, 1'b1);
      idle(2);

      // R3: relative jump, forward, most negative, wrap both ways
      send("R3",  3'd1, 16'h0200, 8'h00, 3'd0, 12'h123, 8'h00, 8'h00, 1'b0);
      send("R3",  3'd1, 16'h4000, 8'h00, 3'd0, 12'h800, 8'h00, 8'h00, 1'b0);
      send("R3",  3'd1, 16'h0005, 8'h00, 3'd0, 12'hFF6, 8'h00, 8'h00, 1'b0);
      send("R10", 3'd1, 16'hFFFE, 8'h00, 3'd0, 12'h7FF, 8'h00, 8'h00, 1'b1);
      idle(1);

      // R4 / R5: every status bit, both polarities, mixed pattern
      for (int s = 0; s < 8; s++) begin
         send("R4", 3'd2, 16'h0800, 8'b1010_0110, 3'(s), 12'h010, 8'h00, 8'h00, 1'b0);
         send("R5", 3'd3, 16'h0800, 8'b1010_0110, 3'(s), 12'h010, 8'h00, 8'h00, 1'b1);
      end
      idle(3);
      // signed greater-or-equal on sign bit clear, same-or-higher on carry clear
      send("R5", 3'd3, 16'h0300, 8'h01, 3'(FLG_SIGN), 12'h002, 8'h00, 8'h00, 1'b0);
      send("R5", 3'd3, 16'h0300, 8'h01, 3'(FLG_CARRY), 12'h002, 8'h00, 8'h00, 1'b0);

      // R6: upper offset bits ignored, negative branch offsets, wrap
      send("R6", 3'd2, 16'h0500, 8'hFF, 3'd1, 12'hF85, 8'h00, 8'h00, 1'b0);
      send("R6", 3'd2, 16'h0500, 8'hFF, 3'd2, 12'h040, 8'h00, 8'h00, 1'b0);
      send("R6", 3'd3, 16'h0010, 8'h00, 3'd6, 12'h07F, 8'h00, 8'h00, 1'b0);
      send("R6", 3'd2, 16'hFFF0, 8'h80, 3'd7, 12'hA3F, 8'h00, 8'h00, 1'b1);
      idle(1);

      // R7: equality skip, both lengths, unequal case
      send("R7", 3'd4, 16'h0600, 8'h00, 3'd0, 12'hFFF, 8'h5A, 8'h5A, 1'b0);
      send("R7", 3'd4, 16'h0600, 8'h00, 3'd0, 12'hFFF, 8'h5A, 8'h5A, 1'b1);
      send("R7", 3'd4, 16'h0600, 8'h00, 3'd0, 12'h000, 8'h5A, 8'hDA, 1'b1);
      send("R7", 3'd4, 16'hFFFE, 8'h00, 3'd0, 12'h000, 8'h00, 8'h00, 1'b1);
      idle(2);

      // R8: bit skips on every bit, set and clear forms
      for (int s = 0; s < 8; s++) begin
         send("R8", 3'd5, 16'h0700, 8'h00, 3'(s), 12'h000, 8'b0110_1001, 8'h00, s[0]);
         send("R8", 3'd6, 16'h0700, 8'hFF, 3'(s), 12'h000, 8'b0110_1001, 8'h00, s[1]);
      end
      idle(3);

      check(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 32'd0);
      @(negedge clk);
      check(res_valid == 1'b0, "R9", "idle valid", 32'(res_valid), 32'd0);
      done = 1'b1;
      finish_run();
   end

endmodule